// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two 8-bit bidirectional buses, A and B. Each transfer direction has its own capture register. The A-to-B register stores the A bus, and the B-to-A register stores the B bus. Each register loads on a rising edge of that direction's own strobe input.

For each direction, a source select chooses what goes onto the destination bus:
- the live value on the opposite bus, or
- the value held in that direction's register.

An active-low output enable and a direction input decide which bus is driven: A only, B only, or neither.

Capture does not depend on which bus is driving. Data can be stored while both buses are isolated, and sent out later.

The pads are split into separate input, output and output-enable vectors for each bus. The core therefore contains no tri-state logic. The two strobes are asynchronous pulses. Each one passes through a synchronizer and a rising-edge detector on the single system clock.

The buses are plain level-driven pins. They have no valid/ready flow, and neither side can exert back-pressure.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset `rst` clears both capture registers to zero.
- R2: A rising edge on `ab_strobe` loads `a_in` into the A-to-B register. The load happens on the third `clk` rising edge after the strobe goes high: two synchronizer stages plus the load edge. Until that edge the old value remains visible.
- R3: A rising edge on `ba_strobe` loads `b_in` into the B-to-A register, with the same three-edge latency. It leaves the A-to-B register untouched.
- R4: A strobe held high loads only once. If the bus changes while the strobe stays high, the stored value does not change.
- R5: While `oe_n` is 1, both `a_oe` and `b_oe` are all zeros.
- R6: While `oe_n` is 0, the bus is chosen by `dir`:
  - `dir` = 0: `a_oe` is all ones and `b_oe` is all zeros.
  - `dir` = 1: `b_oe` is all ones and `a_oe` is all zeros.
- R7: With `sel_ab` = 0, `b_out` equals `a_in` bit for bit, without inversion. With `sel_ba` = 0, `a_out` equals `b_in` in the same way.
- R8: With `sel_ab` = 1, `b_out` shows the A-to-B register. With `sel_ba` = 1, `a_out` shows the B-to-A register.
- R9: `a_oe` and `b_oe` are never both non-zero. Each is always all ones or all zeros.
- R10: Loads occur whatever the values of `oe_n` and `dir`. This includes isolation and the case where the source bus is the one being driven. A value loaded during isolation appears on the bus once output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_strobe | input | 1 | Asynchronous load strobe for the A-to-B register |
| ba_strobe | input | 1 | Asynchronous load strobe for the B-to-A register |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive on bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive on bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
Some properties are checked by assertions on every cycle:
- the two drive enables are never active together, and isolation turns both off;
- the live path passes data through without inversion;
- each register either holds or loads the value present at the previous edge;
- reset clears both registers;
- the edge detector never pulses twice in a row.

Other behaviour can only be shown by the bench scenarios:
- the exact three-edge load latency;
- a single load while a strobe is held high;
- independence of the two registers;
- a value stored during isolation later appearing on the chosen bus, across the combinations of enable, direction and select.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned DEF_WIDTH  = 8;
  localparam int unsigned DEF_STAGES = 2;

  // index of each transfer direction inside the generated slices
  localparam int unsigned PATH_AB = 0;
  localparam int unsigned PATH_BA = 1;
  localparam int unsigned N_PATHS = 2;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e drive_decode(input logic oe_n, input logic dir);
    if (oe_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // R4: a detected edge lasts one cycle only
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R2 / R3: a load takes the value present at that edge
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));
  // R4: without a load the register holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  // R1: reset clears
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/path_mux.sv
module path_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    if (use_stored) y = stored;
    else            y = live;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ab_strobe,
  input  logic             ba_strobe,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  logic [N_PATHS-1:0] strb;
  logic [N_PATHS-1:0] sel;
  logic [N_PATHS-1:0] rise;
  logic [WIDTH-1:0]   src   [N_PATHS];
  logic [WIDTH-1:0]   held  [N_PATHS];
  logic [WIDTH-1:0]   dest  [N_PATHS];
  drive_e             drv;

  assign strb[PATH_AB] = ab_strobe;
  assign strb[PATH_BA] = ba_strobe;
  assign sel[PATH_AB]  = sel_ab;
  assign sel[PATH_BA]  = sel_ba;
  assign src[PATH_AB]  = a_in;
  assign src[PATH_BA]  = b_in;

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    strobe_sync #(.STAGES(STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .strobe (strb[p]),
      .rise   (rise[p])
    );
    capture_reg #(.WIDTH(WIDTH)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (rise[p]),
      .d    (src[p]),
      .q    (held[p])
    );
    path_mux #(.WIDTH(WIDTH)) u_mux (
      .use_stored (sel[p]),
      .live       (src[p]),
      .stored     (held[p]),
      .y          (dest[p])
    );
  end

  assign drv   = drive_decode(oe_n, dir);
  assign b_out = dest[PATH_AB];
  assign a_out = dest[PATH_BA];
  assign a_oe  = {WIDTH{drv == DRV_A}};
  assign b_oe  = {WIDTH{drv == DRV_B}};

  // R9: never both buses driven
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));
  // R5: isolation releases both buses
  assert_isolate_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> ((a_oe == '0) && (b_oe == '0)));
  // R7: live path is non-inverting, both directions
  assert_live_ab_R7: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |-> (b_out == a_in));
  assert_live_ba_R7: assert property (@(posedge clk) disable iff (rst)
    !sel_ba |-> (a_out == b_in));
endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ab_strobe = 1'b0, ba_strobe = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) i_bus_xcvr_reg (
    .clk(clk), .rst(rst), .ab_strobe(ab_strobe), .ba_strobe(ba_strobe),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    string        req;
    logic [W-1:0] aoe, boe, aout, bout;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;  // reference registers
  bit done = 0;

  // driver side: compute expectation from the requirements and enqueue it
  task automatic expect_now(string req);
    item_t it;
    #1;
    it.req  = req;
    it.aoe  = (!oe_n && !dir) ? '1 : '0;
    it.boe  = (!oe_n &&  dir) ? '1 : '0;
    it.aout = sel_ba ? m_ba : b_in;
    it.bout = sel_ab ? m_ab : a_in;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // monitor: pop and compare
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      compared++;
      if (a_oe !== it.aoe || b_oe !== it.boe || a_out !== it.aout || b_out !== it.bout) begin
        mismatched++;
        $display("FAIL %s: got a_oe=%h b_oe=%h a_out=%h b_out=%h exp a_oe=%h b_oe=%h a_out=%h b_out=%h",
                 it.req, a_oe, b_oe, a_out, b_out, it.aoe, it.boe, it.aout, it.bout);
      end
    end
  end

  task automatic set_ctl(logic n, logic d, logic s_ab, logic s_ba);
    oe_n = n; dir = d; sel_ab = s_ab; sel_ba = s_ba;
  endtask

  // pulse a strobe; check old value after 2 edges, new after the 3rd (R2/R3)
  task automatic pulse(bit ab, string req);
    @(negedge clk);
    if (ab) ab_strobe = 1'b1; else ba_strobe = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(req);
    @(negedge clk);
    if (ab) m_ab = a_in; else m_ba = b_in;
    expect_now(req);
    repeat (2) @(negedge clk);
    ab_strobe = 1'b0; ba_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset clears both registers
    set_ctl(0, 1, 1, 1); expect_now("R1");
    set_ctl(0, 0, 1, 1); expect_now("R1");
    // R5: isolation for all select combinations
    for (int s = 0; s < 4; s++) begin
      set_ctl(1, s[0], s[1], s[0]); a_in = 8'h5A; b_in = 8'hA5; expect_now("R5");
    end
    // R6 / R7: live transfer both ways, several patterns
    foreach (q[i]) ;
    for (int k = 0; k < 3; k++) begin
      a_in = (k == 0) ? 8'h5A : (k == 1) ? 8'hA5 : 8'hFF;
      b_in = ~a_in ^ 8'h0F;
      set_ctl(0, 1, 0, 0); expect_now("R7");
      set_ctl(0, 0, 0, 0); expect_now("R6");
    end
    // R10 / R2: load A-to-B during isolation, then show it on B
    set_ctl(1, 0, 1, 1); a_in = 8'h3C; b_in = 8'h00;
    pulse(1, "R2");
    a_in = 8'hE1;
    set_ctl(0, 1, 1, 0); expect_now("R10");
    // R3: B-to-A untouched by the A load
    set_ctl(0, 0, 1, 1); expect_now("R3");
    // R3: load B while A is driven
    b_in = 8'hC3;
    pulse(0, "R3");
    b_in = 8'h12;
    expect_now("R8");
    set_ctl(0, 1, 1, 1); expect_now("R8");
    // R10: load A while A itself is the driven bus
    set_ctl(0, 0, 1, 1); a_in = 8'h77;
    pulse(1, "R10");
    set_ctl(0, 1, 1, 0); expect_now("R10");
    // R4: strobe held high loads only once
    a_in = 8'h11;
    @(negedge clk); ab_strobe = 1'b1;
    repeat (5) @(negedge clk);
    m_ab = 8'h11;
    a_in = 8'h22;
    repeat (5) @(negedge clk);
    expect_now("R4");
    ab_strobe = 1'b0;
    repeat (4) @(negedge clk);
    expect_now("R4");
    // R9: sweep all control combinations
    for (int c = 0; c < 16; c++) begin
      set_ctl(c[0], c[1], c[2], c[3]); a_in = 8'h96; b_in = 8'h69;
      expect_now("R9");
    end
    // R1: reset mid-run clears stored data
    rst = 1'b1; @(negedge clk); rst = 1'b0; m_ab = '0; m_ba = '0;
    set_ctl(0, 1, 1, 1); expect_now("R1");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got hang exp completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule